// File: doc/BRIEF.md
# Switch Stage Fault and Over-Temperature Monitor

This block drives the active-low fault flag of one power switching stage. At every transition of the stage's PWM command it checks the digitized switch-node comparators to tell whether the stage switched properly. On a falling PWM edge the switch node should have dropped. If it is still above the high-side short threshold, the high-side switch is shorted. If it has gone below the negative open threshold, the low-side switch is open. On a rising PWM edge the switch node should have risen. If it is still below the low-side short threshold, the low-side switch is shorted. A single bad check does not raise a fault. Only a run of `FAIL_RUN` consecutive failed checks latches the phase fault, and the latch holds until reset.

Alongside the edge checks, a hysteretic thermal flag watches two comparator inputs: an over-threshold input (hot trip) and an under-release input (cooled). The thermal flag sets once the over input has persisted for a qualification window. That window is set by `THERM_QUAL` and so bounds the assertion delay. The flag clears only when the under-release input is seen. The fault flag goes low whenever either condition is active. A cause code tells the system which condition is active and what kind of check completed the latching run. The block takes no protective action itself.

Two state machines carry the behaviour. The edge-run machine has the states RUN_CLEAR (no pending failures), RUN_COUNTING (one or more consecutive failures) and RUN_LATCHED (phase fault held). Its transitions are:
- fail-first: RUN_CLEAR to RUN_COUNTING.
- fail-more: stays in RUN_COUNTING.
- pass-reset: RUN_COUNTING to RUN_CLEAR.
- fail-limit: RUN_COUNTING to RUN_LATCHED, or straight from RUN_CLEAR when `FAIL_RUN` is 1.

The thermal machine has the states TH_COOL, TH_QUALIFY and TH_HOT. Its transitions are:
- trip-seen: TH_COOL to TH_QUALIFY.
- trip-lost: TH_QUALIFY to TH_COOL.
- trip-confirmed: TH_QUALIFY to TH_HOT.
- cooled: TH_HOT to TH_COOL.

Top module: `pfm_monitor`

## Requirements
- R1: While reset is held and immediately after release, `fault_n_o` is 1 and `cause_o` is 4'b0000.
- R2: A falling PWM edge is a failed check when `sw_hs_i` is 1 (kind 2'b01, high-side short) or when `sw_neg_i` is 1 (kind 2'b11, low-side open). If both are set, kind 2'b01 wins.
- R3: A rising PWM edge is a failed check when `sw_gnd_i` is 1 (kind 2'b10, low-side short).
- R4: The phase fault latches on the cycle after the `FAIL_RUN`-th (default 15) consecutive failed check. After `FAIL_RUN`-1 consecutive failures `fault_n_o` is still 1.
- R5: Any passing check clears the run of consecutive failures.
- R6: In cycles without a PWM transition, the comparator inputs are ignored and the run is unchanged. The first sampled cycle after reset is never treated as an edge.
- R7: Once latched, the phase fault stays active until reset, whatever checks follow.
- R8: The thermal flag sets after `temp_over_i` has been 1 (with `temp_under_i` 0) for `THERM_QUAL`+1 consecutive cycles (default 9). Any break restarts the qualification.
- R9: The thermal flag clears on the cycle after `temp_under_i` is 1. Between thresholds (both inputs 0) it holds its state, and it never latches.
- R10: `fault_n_o` is 0 exactly when the phase fault or the thermal flag is active. In `cause_o`, bit 0 is the thermal flag and bit 1 is the phase fault. Bits [3:2] carry the kind of the check that completed the latching run, and are 2'b00 while no phase fault is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_i | input | 1 | PWM command level (synchronized) |
| sw_hs_i | input | 1 | Switch node above high-side short threshold |
| sw_gnd_i | input | 1 | Switch node below low-side short threshold |
| sw_neg_i | input | 1 | Switch node below negative open threshold |
| temp_over_i | input | 1 | Temperature above trip threshold |
| temp_under_i | input | 1 | Temperature below release threshold |
| fault_n_o | output | 1 | Fault flag, active low |
| cause_o | output | 4 | {kind[1:0], phase fault, thermal} |

## Verification
The bench targets the run boundary. It builds 14 failures, then one passing check, then 14 more failures. A counter that is not cleared by a pass, or that is off by one, would drop the flag too early. It checks the kind recorded at the limit on both edge polarities, including the case where both falling-edge comparators are set; a design with the wrong priority would report an open instead of a short. It holds the comparators high on cycles with no PWM transition, where a design that evaluated levels instead of edges would count phantom failures. For the thermal flag, it breaks the qualification one cycle short of the window and then holds between the thresholds. A design with no qualification or no hysteresis would set too early or release too early.

// File: rtl/pfm_pkg.sv
package pfm_pkg;

    typedef enum logic [1:0] {
        KIND_NONE     = 2'b00,
        KIND_HS_SHORT = 2'b01,
        KIND_LS_SHORT = 2'b10,
        KIND_LS_OPEN  = 2'b11
    } fail_kind_t;

    typedef enum logic [1:0] {
        RUN_CLEAR    = 2'd0,
        RUN_COUNTING = 2'd1,
        RUN_LATCHED  = 2'd2
    } run_state_t;

    typedef enum logic [1:0] {
        TH_COOL    = 2'd0,
        TH_QUALIFY = 2'd1,
        TH_HOT     = 2'd2
    } therm_state_t;

endpackage

// File: rtl/pfm_edge_check.sv
module pfm_edge_check
    import pfm_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       pwm_i,
    input  logic       sw_hs_i,
    input  logic       sw_gnd_i,
    input  logic       sw_neg_i,
    output logic       chk_vld_o,
    output logic       chk_fail_o,
    output fail_kind_t chk_kind_o
);

    logic pwm_q;
    logic seen_q;
    logic rise;
    logic fall;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pwm_q  <= 1'b0;
            seen_q <= 1'b0;
        end else begin
            pwm_q  <= pwm_i;
            seen_q <= 1'b1;
        end
    end

    // An edge is only qualified once a previous level has been sampled (R6)
    assign rise = seen_q &  pwm_i & ~pwm_q;
    assign fall = seen_q & ~pwm_i &  pwm_q;

    always_comb begin
        chk_vld_o  = rise | fall;
        chk_fail_o = 1'b0;
        chk_kind_o = KIND_NONE;
        if (fall) begin
            // high-side short has priority over low-side open (R2)
            if (sw_hs_i) begin
                chk_fail_o = 1'b1;
                chk_kind_o = KIND_HS_SHORT;
            end else if (sw_neg_i) begin
                chk_fail_o = 1'b1;
                chk_kind_o = KIND_LS_OPEN;
            end
        end else if (rise) begin
            if (sw_gnd_i) begin
                chk_fail_o = 1'b1;
                chk_kind_o = KIND_LS_SHORT;   // R3
            end
        end
    end

endmodule

// File: rtl/pfm_run_fsm.sv
module pfm_run_fsm
    import pfm_pkg::*;
#(
    parameter int FAIL_RUN = 15
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       chk_vld_i,
    input  logic       chk_fail_i,
    input  fail_kind_t chk_kind_i,
    output logic       phase_flt_o,
    output fail_kind_t phase_kind_o
);

    localparam int CW = (FAIL_RUN < 2) ? 1 : $clog2(FAIL_RUN + 1);
    localparam logic [CW-1:0] LAST = CW'(FAIL_RUN - 1);

    run_state_t      state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;
    fail_kind_t      kind_q, kind_d;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= RUN_CLEAR;
            cnt_q   <= '0;
            kind_q  <= KIND_NONE;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            kind_q  <= kind_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        kind_d  = kind_q;
        unique case (state_q)
            RUN_CLEAR: begin
                if (chk_vld_i && chk_fail_i) begin
                    if (FAIL_RUN <= 1) begin        // fail-limit
                        state_d = RUN_LATCHED;
                        kind_d  = chk_kind_i;
                    end else begin                  // fail-first
                        state_d = RUN_COUNTING;
                        cnt_d   = CW'(1);
                    end
                end
            end
            RUN_COUNTING: begin
                if (chk_vld_i) begin
                    if (!chk_fail_i) begin          // pass-reset (R5)
                        state_d = RUN_CLEAR;
                        cnt_d   = '0;
                    end else if (cnt_q == LAST) begin // fail-limit (R4)
                        state_d = RUN_LATCHED;
                        kind_d  = chk_kind_i;
                    end else begin                  // fail-more
                        cnt_d   = cnt_q + CW'(1);
                    end
                end
            end
            RUN_LATCHED: begin
                state_d = RUN_LATCHED;              // held until reset (R7)
            end
            default: begin
                state_d = RUN_CLEAR;
                cnt_d   = '0;
                kind_d  = KIND_NONE;
            end
        endcase
    end

    // outputs
    always_comb begin
        phase_flt_o  = (state_q == RUN_LATCHED);
        phase_kind_o = (state_q == RUN_LATCHED) ? kind_q : KIND_NONE;
    end

endmodule

// File: rtl/pfm_therm_fsm.sv
module pfm_therm_fsm
    import pfm_pkg::*;
#(
    parameter int THERM_QUAL = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic temp_over_i,
    input  logic temp_under_i,
    output logic hot_o
);

    localparam int QW = (THERM_QUAL < 2) ? 1 : $clog2(THERM_QUAL + 1);
    localparam logic [QW-1:0] QLAST = QW'(THERM_QUAL - 1);

    therm_state_t  state_q, state_d;
    logic [QW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= TH_COOL;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TH_COOL: begin
                if (temp_over_i) begin              // trip-seen
                    state_d = TH_QUALIFY;
                    cnt_d   = '0;
                end
            end
            TH_QUALIFY: begin
                if (!temp_over_i) begin             // trip-lost (R8)
                    state_d = TH_COOL;
                    cnt_d   = '0;
                end else if (cnt_q == QLAST) begin  // trip-confirmed
                    state_d = TH_HOT;
                    cnt_d   = '0;
                end else begin
                    cnt_d   = cnt_q + QW'(1);
                end
            end
            TH_HOT: begin
                if (temp_under_i) begin             // cooled (R9)
                    state_d = TH_COOL;
                end
            end
            default: begin
                state_d = TH_COOL;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        hot_o = (state_q == TH_HOT);
    end

endmodule

// File: rtl/pfm_monitor.sv
module pfm_monitor
    import pfm_pkg::*;
#(
    parameter int FAIL_RUN   = 15,
    parameter int THERM_QUAL = 8
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       pwm_i,
    input  logic       sw_hs_i,
    input  logic       sw_gnd_i,
    input  logic       sw_neg_i,
    input  logic       temp_over_i,
    input  logic       temp_under_i,
    output logic       fault_n_o,
    output logic [3:0] cause_o
);

    logic       chk_vld;
    logic       chk_fail;
    fail_kind_t chk_kind;
    logic       phase_flt;
    fail_kind_t phase_kind;
    logic       hot;

    pfm_edge_check u_edge (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .pwm_i      (pwm_i),
        .sw_hs_i    (sw_hs_i),
        .sw_gnd_i   (sw_gnd_i),
        .sw_neg_i   (sw_neg_i),
        .chk_vld_o  (chk_vld),
        .chk_fail_o (chk_fail),
        .chk_kind_o (chk_kind)
    );

    pfm_run_fsm #(.FAIL_RUN(FAIL_RUN)) u_run (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .chk_vld_i    (chk_vld),
        .chk_fail_i   (chk_fail),
        .chk_kind_i   (chk_kind),
        .phase_flt_o  (phase_flt),
        .phase_kind_o (phase_kind)
    );

    pfm_therm_fsm #(.THERM_QUAL(THERM_QUAL)) u_therm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .temp_over_i  (temp_over_i),
        .temp_under_i (temp_under_i),
        .hot_o        (hot)
    );

    // R10: flag is the OR of both conditions; cause reports which
    always_comb begin
        fault_n_o = ~(phase_flt | hot);
        cause_o   = {phase_kind, phase_flt, hot};
    end

endmodule

// File: rtl/pfm_monitor_chk.sv
module pfm_monitor_chk #(
    parameter int THERM_QUAL = 8
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       pwm_i,
    input logic       temp_over_i,
    input logic       temp_under_i,
    input logic       fault_n_o,
    input logic [3:0] cause_o
);

    logic [15:0] over_run;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            over_run <= '0;
        end else if (temp_over_i && !temp_under_i) begin
            if (over_run != 16'hFFFF) over_run <= over_run + 16'd1;
        end else begin
            over_run <= '0;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk_i)
        $rose(rst_ni) |-> (fault_n_o && cause_o == 4'b0000));

    assert_kind_needs_phase_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cause_o[1] |-> (cause_o[3:2] == 2'b00));

    assert_latch_after_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cause_o[1]) |-> ($past(pwm_i) != $past(pwm_i, 2)));

    assert_phase_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cause_o[1] |=> cause_o[1]);

    assert_therm_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (over_run > 16'(THERM_QUAL)) |-> cause_o[0]);

    assert_therm_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cause_o[0] && !temp_under_i) |=> cause_o[0]);

    assert_flag_or_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_n_o == !(cause_o[0] || cause_o[1]));

endmodule

bind pfm_monitor pfm_monitor_chk #(.THERM_QUAL(THERM_QUAL)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pwm_i        (pwm_i),
    .temp_over_i  (temp_over_i),
    .temp_under_i (temp_under_i),
    .fault_n_o    (fault_n_o),
    .cause_o      (cause_o)
);

// File: tb/pfm_monitor_tb_top.sv
module pfm_monitor_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       pwm, hs, gnd, neg, over, under;
    logic       fault_n;
    logic [3:0] cause;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pfm_monitor dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .pwm_i        (pwm),
        .sw_hs_i      (hs),
        .sw_gnd_i     (gnd),
        .sw_neg_i     (neg),
        .temp_over_i  (over),
        .temp_under_i (under),
        .fault_n_o    (fault_n),
        .cause_o      (cause)
    );

    // {pwm, hs, gnd, neg, exp_fault_n, exp_cause[3:0]}
    localparam logic [8:0] VEC [8] = '{
        9'b1000_1_0000,   // passing rise
        9'b0000_1_0000,   // passing fall
        9'b1010_1_0000,   // failed rise
        9'b1111_1_0000,   // no edge, comparators ignored
        9'b0100_1_0000,   // failed fall
        9'b0000_1_0000,   // no edge
        9'b1000_1_0000,   // passing rise
        9'b0001_1_0000    // failed fall (open)
    };

    task automatic check(input string req, input logic [4:0] exp);
        checks++;
        if ({fault_n, cause} !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, {fault_n, cause}, exp);
        end
    endtask

    task automatic step(input logic p, h, g, n, o, u);
        pwm = p; hs = h; gnd = g; neg = n; over = o; under = u;
        @(negedge clk);
    endtask

    task automatic do_reset(input logic p);
        rst_n = 1'b0;
        pwm = p; hs = 0; gnd = 0; neg = 0; over = 0; under = 0;
        repeat (2) @(negedge clk);
        check("R1 in reset", 5'b1_0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 5'b1_0000);
    endtask

    // failing edge: rise with gnd, fall with hs and neg both set
    task automatic fail_edge;
        if (pwm == 1'b0) step(1, 0, 1, 0, over, under);
        else             step(0, 1, 0, 1, over, under);
    endtask

    task automatic pass_edge;
        step(~pwm, 0, 0, 0, over, under);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset(1'b0);

        // table walk: mixed passes, isolated failures, non-edge cycles (R6, R3, R2)
        foreach (VEC[i]) begin
            step(VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5], 0, 0);
            check($sformatf("R6 table vector %0d", i), VEC[i][4:0]);
        end

        // R4: exact run length, ending on a rising edge (R3 kind 10)
        do_reset(1'b0);
        for (int k = 0; k < 14; k++) fail_edge();
        check("R4 fourteen failures", 5'b1_0000);
        fail_edge();
        check("R4 R3 fifteenth failure latches", 5'b0_1010);
        // R7: passing checks do not clear
        for (int k = 0; k < 4; k++) pass_edge();
        check("R7 latched after passes", 5'b0_1010);
        do_reset(1'b0);

        // R5 and R6: pass mid-run, idle cycles with comparators set
        for (int k = 0; k < 14; k++) fail_edge();
        pass_edge();                       // pwm now 1
        for (int k = 0; k < 14; k++) fail_edge();
        step(pwm, 1, 1, 1, 0, 0);          // no edge
        step(pwm, 1, 1, 1, 0, 0);
        check("R5 R6 run cleared by pass", 5'b1_0000);
        step(0, 0, 0, 1, 0, 0);            // falling, open only
        check("R2 open kind at limit", 5'b0_1110);

        // R2: priority of high-side short over open on falling edge
        do_reset(1'b1);
        for (int k = 0; k < 15; k++) fail_edge();
        check("R2 short over open priority", 5'b0_0110);

        // R8 thermal qualification
        do_reset(1'b0);
        for (int k = 0; k < 8; k++) step(0, 0, 0, 0, 1, 0);
        step(0, 0, 0, 0, 0, 0);
        check("R8 broken qualification", 5'b1_0000);
        for (int k = 0; k < 8; k++) step(0, 0, 0, 0, 1, 0);
        check("R8 one short of window", 5'b1_0000);
        step(0, 0, 0, 0, 1, 0);
        check("R8 thermal set", 5'b0_0001);
        // R9 hysteresis
        for (int k = 0; k < 5; k++) step(0, 0, 0, 0, 0, 0);
        check("R9 holds between thresholds", 5'b0_0001);
        step(0, 0, 0, 0, 0, 1);
        check("R9 released", 5'b1_0000);

        // R10: both conditions, then thermal clears alone
        for (int k = 0; k < 15; k++) fail_edge();
        check("R10 phase only", 5'b0_1010);
        for (int k = 0; k < 9; k++) step(pwm, 0, 0, 0, 1, 0);
        check("R10 both active", 5'b0_1011);
        step(pwm, 0, 0, 0, 0, 1);
        check("R10 thermal cleared, phase held", 5'b0_1010);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule